// File: doc/BRIEF.md
# Timestamped Sample FIFO Channel

This block is one acquisition channel of a multichannel sampling peripheral. Digitized samples arrive on a valid/ready input. Each accepted sample is joined with the value of a free-running 17-bit timestamp counter into a 32-bit word, and that word is queued in a four-entry FIFO. A register-style read port shows the oldest word and removes it on a pop strobe. The current fill level is visible at all times.

Four sticky event flags record that the FIFO became full, that it became empty, that a pop found it empty (underflow) and that a sample was lost (overflow). Each flag has a mask bit and a write-one-to-clear input. A mode pin hands the channel to a DMA engine instead. In that mode a request is raised while data is queued, and the interrupt line stays low. A global enable gates sampling. A soft reset returns the FIFO, the flags and the counter to their reset state.

Back-pressure: `smp_ready` is high when the channel is enabled and the FIFO has space. The converter feeding the channel cannot stall. A sample presented with `smp_valid` while `smp_ready` is low is therefore discarded, not held, and the loss is recorded as an overflow.

Top module: `sfc_chan`

## Requirements
- R1: A queued word carries the sample in bits [13:0] and, in bits [31:14], the timestamp counter value of the cycle in which the sample was accepted. That value is zero-extended from 17 to 18 bits, so bit 31 is 0.
- R2: The FIFO holds 4 words in arrival order. `fill_level` (0..4) updates one cycle after a push or pop. `rd_data` shows the oldest word combinationally, and `rd_pop` removes it at the clock edge.
- R3: `smp_ready` equals `glb_en` AND level not 4. A sample presented with `smp_valid` while enabled and full is dropped and sets status bit 3 (overflow).
- R4: A pop while the FIFO is empty leaves the level at 0 and sets status bit 2 (underflow). While the FIFO is empty, `rd_data` reads zero.
- R5: Status bit 0 (full) is set by a push that brings the level to 4. Status bit 1 (empty) is set by a pop that brings the level to 0.
- R6: A 1 in `irq_clr` clears the matching status bit at the next clock edge. A 0 leaves the bit unchanged, and set bits stay set until cleared.
- R7: When a status bit's event fires in the same cycle as a clear of that bit, the bit stays set.
- R8: With `dma_mode` 0, `irq_o` is high when any status bit is set whose `irq_en` bit is 1. With `dma_mode` 1, `irq_o` is low.
- R9: `dma_req` is high exactly when `dma_mode` is 1 and the level is not 0.
- R10: `ts_count` increments by one per cycle while `ts_en` is 1 and wraps modulo 2^17. `ts_clr` zeroes it at the next edge and takes priority over `ts_en`.
- R11: With `glb_en` 0, `smp_valid` has no effect: the level does not change and no overflow is recorded.
- R12: `soft_rst` empties the FIFO, clears all status bits and zeroes the counter at the next edge. It overrides every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global sampling enable |
| soft_rst | input | 1 | Synchronous clear of FIFO, status and counter |
| smp_valid | input | 1 | Sample valid strobe |
| smp_ready | output | 1 | Channel can accept a sample |
| smp_data | input | 14 | Sample value |
| rd_pop | input | 1 | Remove the oldest word |
| rd_data | output | 32 | Oldest word (zero when empty) |
| fill_level | output | 3 | Number of queued words |
| irq_en | input | 4 | Per-source interrupt mask |
| irq_clr | input | 4 | Write-one-to-clear strobe for status bits |
| irq_status | output | 4 | Sticky flags: bit3 overflow, bit2 underflow, bit1 empty, bit0 full |
| irq_o | output | 1 | Interrupt request |
| dma_mode | input | 1 | 1 selects DMA service |
| dma_req | output | 1 | DMA request |
| ts_en | input | 1 | Timestamp counter enable |
| ts_clr | input | 1 | Timestamp counter synchronous clear |
| ts_count | output | 17 | Current timestamp |

## Verification
Some rules are checked on every cycle: the ready rule, the DMA request and interrupt masking in DMA mode, the zero read from an empty FIFO, the setting of overflow and underflow, flag stickiness, counter increment and the effect of soft reset. FIFO ordering, the exact timestamp captured in a word, the full and empty edge events, same-cycle set-over-clear and counter wrap appear only in the bench's scenarios. Those scenarios compare the read data and the flags against values worked out from the requirements.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int SMP_W_DEF  = 14;
  localparam int TS_W_DEF   = 17;
  localparam int TSF_W_DEF  = 18;
  localparam int DEPTH_DEF  = 4;

  // status bit positions (software decodes these)
  localparam int EV_FULL    = 0;
  localparam int EV_EMPTY   = 1;
  localparam int EV_UNDER   = 2;
  localparam int EV_OVER    = 3;
  localparam int NUM_EV     = 4;
endpackage

// File: rtl/sfc_tstamp.sv
module sfc_tstamp #(
  parameter int TS_W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclr,
  input  logic            en,
  output logic [TS_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (sclr)   count <= '0;
    else if (en)     count <= count + 1'b1;
  end
endmodule

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [W-1:0]     mem [DEPTH];

  assign full    = (level == LVL_MAX);
  assign empty   = (level == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign rdata   = empty ? '0 : mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[gi] <= '0;
        else if (push_ok && (wr_ptr == PTR_W'(gi)))
          mem[gi] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sfc_irq.sv
module sfc_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  input  logic         dma_mode,
  output logic [N-1:0] status,
  output logic         irq
);
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_flag
      // an event in the same cycle wins over a clear
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       status[gi] <= 1'b0;
        else if (flush)   status[gi] <= 1'b0;
        else if (evt[gi]) status[gi] <= 1'b1;
        else if (clr[gi]) status[gi] <= 1'b0;
      end
    end
  endgenerate

  assign irq = !dma_mode && |(status & en);
endmodule

// File: rtl/sfc_chan.sv
module sfc_chan
  import sfc_pkg::*;
#(
  parameter int SMP_W = SMP_W_DEF,
  parameter int TS_W  = TS_W_DEF,
  parameter int TSF_W = TSF_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int WORD_W = SMP_W + TSF_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              soft_rst,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rd_data,
  output logic [LVL_W-1:0]  fill_level,
  input  logic [NUM_EV-1:0] irq_en,
  input  logic [NUM_EV-1:0] irq_clr,
  output logic [NUM_EV-1:0] irq_status,
  output logic              irq_o,
  input  logic              dma_mode,
  output logic              dma_req,
  input  logic              ts_en,
  input  logic              ts_clr,
  output logic [TS_W-1:0]   ts_count
);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(DEPTH - 1);

  logic              push_req;
  logic              f_full, f_empty, push_ok, pop_ok;
  logic [WORD_W-1:0] word_in;
  logic [NUM_EV-1:0] evt;

  sfc_tstamp #(.TS_W(TS_W)) u_ts (
    .clk   (clk),
    .rst_n (rst_n),
    .sclr  (soft_rst | ts_clr),
    .en    (ts_en),
    .count (ts_count)
  );

  // timestamp field is wider than the counter: pad with zeros
  assign word_in  = {{(TSF_W - TS_W){1'b0}}, ts_count, smp_data};
  assign push_req = glb_en && smp_valid;

  sfc_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (soft_rst),
    .push    (push_req),
    .pop     (rd_pop),
    .wdata   (word_in),
    .rdata   (rd_data),
    .level   (fill_level),
    .full    (f_full),
    .empty   (f_empty),
    .push_ok (push_ok),
    .pop_ok  (pop_ok)
  );

  always_comb begin
    evt           = '0;
    evt[EV_OVER]  = push_req && f_full;
    evt[EV_UNDER] = rd_pop && f_empty;
    evt[EV_FULL]  = push_ok && !pop_ok && (fill_level == LVL_LAST);
    evt[EV_EMPTY] = pop_ok && !push_ok && (fill_level == LVL_ONE);
  end

  sfc_irq #(.N(NUM_EV)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (soft_rst),
    .evt      (evt),
    .clr      (irq_clr),
    .en       (irq_en),
    .dma_mode (dma_mode),
    .status   (irq_status),
    .irq      (irq_o)
  );

  assign smp_ready = glb_en && !f_full;
  assign dma_req   = dma_mode && !f_empty;
endmodule

// File: rtl/sfc_chan_chk.sv
module sfc_chan_chk #(
  parameter int SMP_W = 14,
  parameter int TS_W  = 17,
  parameter int TSF_W = 18,
  parameter int DEPTH = 4,
  localparam int WORD_W = SMP_W + TSF_W,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glb_en,
  input logic              soft_rst,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic              rd_pop,
  input logic [WORD_W-1:0] rd_data,
  input logic [LVL_W-1:0]  fill_level,
  input logic [3:0]        irq_clr,
  input logic [3:0]        irq_status,
  input logic              irq_o,
  input logic              dma_mode,
  input logic              dma_req,
  input logic              ts_en,
  input logic              ts_clr,
  input logic [TS_W-1:0]   ts_count
);
  localparam logic [LVL_W-1:0] LMAX = LVL_W'(DEPTH);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LMAX); // R2
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready == (glb_en && fill_level != LMAX)); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && smp_valid && fill_level == LMAX && !soft_rst) |=> irq_status[3]); // R3
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fill_level == '0 && !soft_rst) |=> irq_status[2]); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> (rd_data == '0)); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((irq_status & $past(irq_status & ~irq_clr)) == $past(irq_status & ~irq_clr))); // R6
  AST_DMA_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> !irq_o); // R8
  AST_DMA_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req == (dma_mode && fill_level != '0)); // R9
  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_en && !ts_clr && !soft_rst) |=> (ts_count == TS_W'($past(ts_count) + 1'b1))); // R10
  AST_TS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clr |=> (ts_count == '0)); // R10
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !rd_pop && !soft_rst) |=> $stable(fill_level)); // R11
  AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (fill_level == '0 && irq_status == '0 && ts_count == '0)); // R12
endmodule

bind sfc_chan sfc_chan_chk #(
  .SMP_W(SMP_W), .TS_W(TS_W), .TSF_W(TSF_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .soft_rst(soft_rst),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .rd_pop(rd_pop),
  .rd_data(rd_data), .fill_level(fill_level), .irq_clr(irq_clr),
  .irq_status(irq_status), .irq_o(irq_o), .dma_mode(dma_mode),
  .dma_req(dma_req), .ts_en(ts_en), .ts_clr(ts_clr), .ts_count(ts_count)
);

// File: tb/sim_sfc_chan.sv
`timescale 1ns/1ps
module sim_sfc_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en, soft_rst, smp_valid, smp_ready, rd_pop;
  logic [13:0] smp_data;
  logic [31:0] rd_data;
  logic [2:0]  fill_level;
  logic [3:0]  irq_en, irq_clr, irq_status;
  logic        irq_o, dma_mode, dma_req, ts_en, ts_clr;
  logic [16:0] ts_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk; // 250 MHz

  sfc_chan u0 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .soft_rst(soft_rst),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .fill_level(fill_level),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status),
    .irq_o(irq_o), .dma_mode(dma_mode), .dma_req(dma_req),
    .ts_en(ts_en), .ts_clr(ts_clr), .ts_count(ts_count)
  );

  typedef struct packed {
    logic        vld;
    logic [13:0] d;
    logic        pop;
    logic [3:0]  clr;
    logic [2:0]  lvl;
    logic [3:0]  st;
    logic [31:0] head;
  } vec_t;

  // status bits: 3 overflow, 2 underflow, 1 empty, 0 full
  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 14'h0011, 1'b0, 4'b0000, 3'd1, 4'b0000, 32'h11},
    '{1'b1, 14'h0022, 1'b0, 4'b0000, 3'd2, 4'b0000, 32'h11},
    '{1'b1, 14'h0033, 1'b0, 4'b0000, 3'd3, 4'b0000, 32'h11},
    '{1'b1, 14'h0044, 1'b0, 4'b0000, 3'd4, 4'b0001, 32'h11},
    '{1'b1, 14'h0055, 1'b0, 4'b0000, 3'd4, 4'b1001, 32'h11},
    '{1'b0, 14'h0000, 1'b1, 4'b0000, 3'd3, 4'b1001, 32'h22},
    '{1'b0, 14'h0000, 1'b0, 4'b1001, 3'd3, 4'b0000, 32'h22},
    '{1'b0, 14'h0000, 1'b1, 4'b0000, 3'd2, 4'b0000, 32'h33},
    '{1'b1, 14'h0066, 1'b1, 4'b0000, 3'd2, 4'b0000, 32'h44},
    '{1'b0, 14'h0000, 1'b1, 4'b0000, 3'd1, 4'b0000, 32'h66},
    '{1'b0, 14'h0000, 1'b1, 4'b0000, 3'd0, 4'b0010, 32'h0},
    '{1'b0, 14'h0000, 1'b1, 4'b0000, 3'd0, 4'b0110, 32'h0},
    '{1'b1, 14'h0077, 1'b0, 4'b0100, 3'd1, 4'b0010, 32'h77},
    '{1'b0, 14'h0000, 1'b1, 4'b0010, 3'd0, 4'b0010, 32'h0},
    '{1'b0, 14'h0000, 1'b0, 4'b0010, 3'd0, 4'b0000, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    smp_valid = 0; rd_pop = 0; irq_clr = '0; soft_rst = 0; ts_clr = 0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    glb_en = 1; dma_mode = 0; irq_en = 4'hF; ts_en = 0; smp_data = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R2, R12)
    chk("R2 reset level", 32'(fill_level), 0);
    chk("R12 reset status", 32'(irq_status), 0);
    chk("R4 reset rd_data zero", rd_data, 0);
    chk("R3 reset ready", 32'(smp_ready), 1);
    chk("R10 reset ts", 32'(ts_count), 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      smp_valid = TBL[i].vld; smp_data = TBL[i].d;
      rd_pop = TBL[i].pop; irq_clr = TBL[i].clr;
      @(negedge clk);
      idle();
      #1;
      chk($sformatf("R2 level step %0d", i), 32'(fill_level), 32'(TBL[i].lvl));
      chk($sformatf("R5/R6/R7 status step %0d", i), 32'(irq_status), 32'(TBL[i].st));
      chk($sformatf("R2 head step %0d", i), rd_data, TBL[i].head);
      chk($sformatf("R8 irq step %0d", i), 32'(irq_o), 32'(|TBL[i].st));
    end

    // timestamp counting and capture: R10, R1
    ts_clr = 1; @(negedge clk); ts_clr = 0;
    chk("R10 clear", 32'(ts_count), 0);
    ts_en = 1;
    repeat (10) @(negedge clk);
    chk("R10 count 10", 32'(ts_count), 10);
    smp_valid = 1; smp_data = 14'h1ABC;
    @(negedge clk);
    smp_valid = 0; ts_en = 0;
    chk("R1 packed word", rd_data, {1'b0, 17'd10, 14'h1ABC});
    @(negedge clk);
    chk("R10 hold when disabled", 32'(ts_count), 11);
    ts_en = 1; ts_clr = 1; @(negedge clk); ts_clr = 0;
    chk("R10 clear over enable", 32'(ts_count), 0);
    repeat (131071) @(negedge clk);
    chk("R10 top value", 32'(ts_count), 32'h1FFFF);
    @(negedge clk);
    chk("R10 wrap", 32'(ts_count), 0);
    ts_en = 0;

    // pop the word: empty flag sets
    rd_pop = 1; @(negedge clk); rd_pop = 0;
    chk("R5 empty flag", 32'(irq_status), 32'b0010);

    // masking: R8
    irq_en = 4'b0000; #1;
    chk("R8 masked", 32'(irq_o), 0);
    irq_en = 4'b0010; #1;
    chk("R8 enabled source", 32'(irq_o), 1);
    irq_en = 4'b1101; #1;
    chk("R8 other sources only", 32'(irq_o), 0);
    irq_en = 4'b0010; dma_mode = 1; #1;
    chk("R8 dma mode holds irq low", 32'(irq_o), 0);
    chk("R9 no request when empty", 32'(dma_req), 0);
    smp_valid = 1; smp_data = 14'h0123; @(negedge clk); smp_valid = 0;
    chk("R9 request when not empty", 32'(dma_req), 1);
    dma_mode = 0; #1;
    chk("R9 no request in irq mode", 32'(dma_req), 0);

    // global enable off: R11
    glb_en = 0; #1;
    chk("R11 ready low", 32'(smp_ready), 0);
    smp_valid = 1; smp_data = 14'h0999; @(negedge clk); smp_valid = 0;
    chk("R11 level unchanged", 32'(fill_level), 1);
    chk("R11 no overflow", 32'(irq_status[3]), 0);
    chk("R11 head unchanged", rd_data, 32'h0123);
    glb_en = 1;

    // fill then soft reset: R12
    ts_en = 1;
    repeat (4) begin smp_valid = 1; @(negedge clk); end
    smp_valid = 0;
    chk("R3 overflow on full", 32'(irq_status[3]), 1);
    soft_rst = 1; smp_valid = 1; rd_pop = 1;
    @(negedge clk);
    idle(); ts_en = 0;
    chk("R12 level", 32'(fill_level), 0);
    chk("R12 status", 32'(irq_status), 0);
    chk("R12 ts", 32'(ts_count), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule